// File: doc/BRIEF.md
# Conversion Instruction Sequencer

This block walks a small store of 16-bit conversion instructions. For each one it asks a converter datapath for a conversion or for a limit comparison. Each cycle it presents an instruction index to the store, which returns that entry combinationally. The block latches the entry and then decodes it into outputs:

- the positive-side and negative-side channel selects;
- a ground-reference flag;
- a resolution select;
- a comparison-mode select;
- a limit select, used in comparison mode.

A request/done handshake paces the converter.

Four kinds of gating control how the walk progresses:

- **Sequence end.** A sequence-end bit sends the walk back to entry 0. Without that bit, the walk wraps after the last entry.
- **Halt bit.** A halt bit stops the walk before the entry executes. When it does, the block pulses an interrupt and a clear of the run bit, so the host's run bit must drop on that edge. Entry 0 ignores the halt bit on the first pass after a reset.
- **External edge.** The block can hold a conversion until a synchronised rising edge on an external pin.
- **Delay.** It can insert a delay taken from a 16-bit down-counter before acquisition.

The host drives two inputs: a run bit and a soft-reset level.

Top module: `conv_seq`

## Requirements
- R1: After `rst_n` or `soft_rst`, `instr_idx` is 0, `conv_req` and `pause_irq` are low, and the sequencer latches entry 0 and issues no request until `start` is 1.
- R2: When the executing entry has bit 0 (sequence end) set, the entry fetched after its last `conv_done` is entry 0.
- R3: Without bit 0, `instr_idx` advances by one after each entry completes, and wraps from `NUM_INSTR-1` to 0.
- R4: A fetched entry with bit 1 (halt) set, other than entry 0 on its first pass, raises `pause_irq` and `start_clr` for one cycle and issues no request. It leaves `instr_idx` unchanged. A later `start` = 1 executes that entry without a new interrupt.
- R5: On the first execution of entry 0 after a reset, bit 1 is ignored and no `pause_irq` is raised. On every later return to entry 0, bit 1 halts as in R4.
- R6: While a request is active, `pos_ch` equals entry bits 4:2 and `neg_ch` equals bits 7:5. `neg_gnd` is 1 exactly when bits 7:5 are 000, and `res_8bit` equals bit 10.
- R7: If `start` is cleared during an entry, that entry still completes. The sequencer then fetches the next entry and issues no further request.
- R8: One cycle after `soft_rst` is sampled high, `instr_idx` is 0 and `conv_req` is low.
- R9: With bit 8 set, the request waits for a rising edge of `sync_in` seen while waiting. `conv_req` rises `SYNC_STAGES`+1 clock edges after the edge, which is 3 by default.
- R10: With bit 11 set, `cmp_mode` is 1 and the entry makes two requests, the first with `lim_sel` 0 and the second with `lim_sel` 1. With bit 8 also set, each request needs its own `sync_in` edge.
- R11: With bit 9 set, the down-counter is loaded from `tmr_value` and no request is made until it reaches zero. The first request comes exactly `tmr_value`+1 cycles later than it would without bit 9.
- R12: `conv_req` stays high until `conv_done` is sampled high and drops on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to entry 0 fetch |
| start | input | 1 | Host run bit |
| instr_word | input | 16 | Entry read at `instr_idx` |
| sync_in | input | 1 | External conversion trigger (asynchronous) |
| tmr_value | input | TMR_W | Delay count for bit 9 entries |
| conv_done | input | 1 | Converter completion |
| instr_idx | output | IDX_W | Index of the entry being fetched or executed |
| pos_ch | output | 3 | Positive-side channel |
| neg_ch | output | 3 | Negative-side channel |
| neg_gnd | output | 1 | Negative side is ground |
| res_8bit | output | 1 | Short resolution selected |
| cmp_mode | output | 1 | Limit-comparison request |
| lim_sel | output | 1 | Which limit the comparison uses |
| conv_req | output | 1 | Conversion/comparison request |
| pause_irq | output | 1 | Halt interrupt pulse |
| start_clr | output | 1 | Clear pulse for the run bit |

## Verification
Every combination of the six channel bits is swept, with resolution alternating, so that a swapped or shifted field is told apart from a correct decode. Short looped programs, a full eight-entry program and halt placements at entry 0 and entry 1 separate the first-pass exemption from the halt on later returns. Request latency is measured with and without the delay bit across several counts, and after a sync edge, so that off-by-one errors in the counter or in the synchroniser depth show up as exact cycle differences. Comparison-mode programs with and without sync gating check that both limit requests appear and that each needs its own edge.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

   // entry layout; bit positions are decoded by the sequencer
   typedef struct packed {
      logic [3:0] rsvd;
      logic       cmp;
      logic       res8;
      logic       tmr;
      logic       sync;
      logic [2:0] neg;
      logic [2:0] pos;
      logic       pause;
      logic       last;
   } instr_t;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_CHECK,
      ST_HOLD,
      ST_EXEC,
      ST_TWAIT,
      ST_ACQ,
      ST_ARM,
      ST_CONV
   } seq_state_t;

endpackage

// File: rtl/conv_seq_sync.sv
module conv_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("conv_seq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], d};
   end

   assign rise = pipe[STAGES-1] & ~pipe[STAGES];

   assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] value,
   output logic         zero
);

   generate
      if (W < 1) begin : g_bad_width
         $error("conv_seq_timer: W must be positive");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (load)           cnt <= value;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/conv_seq.sv
module conv_seq
   import conv_seq_pkg::*;
#(
   parameter int NUM_INSTR   = 8,
   parameter int TMR_W       = 16,
   parameter int ACQ_CYCLES  = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(NUM_INSTR),
   localparam int ACQ_W      = $clog2(ACQ_CYCLES) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             start,
   input  logic [15:0]      instr_word,
   input  logic             sync_in,
   input  logic [TMR_W-1:0] tmr_value,
   input  logic             conv_done,
   output logic [IDX_W-1:0] instr_idx,
   output logic [2:0]       pos_ch,
   output logic [2:0]       neg_ch,
   output logic             neg_gnd,
   output logic             res_8bit,
   output logic             cmp_mode,
   output logic             lim_sel,
   output logic             conv_req,
   output logic             pause_irq,
   output logic             start_clr
);

   generate
      if (NUM_INSTR < 2 || NUM_INSTR > 16) begin : g_bad_depth
         $error("conv_seq: NUM_INSTR must lie in 2..16");
      end
      if (ACQ_CYCLES < 1) begin : g_bad_acq
         $error("conv_seq: ACQ_CYCLES must be at least 1");
      end
      if ($bits(instr_t) != 16) begin : g_bad_layout
         $error("conv_seq: entry layout must be 16 bits");
      end
   endgenerate

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_INSTR - 1);
   localparam logic [ACQ_W-1:0] ACQ_END  = ACQ_W'(ACQ_CYCLES - 1);

   seq_state_t       state;
   instr_t           cur;
   logic             first_pass;
   logic [ACQ_W-1:0] acq_cnt;
   logic             sync_rise;
   logic             tmr_zero;
   logic             tmr_load;
   logic             unused_rsvd;

   conv_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_in),
      .rise  (sync_rise)
   );

   assign tmr_load = (state == ST_EXEC) && cur.tmr;

   conv_seq_timer #(.W(TMR_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .load  (tmr_load),
      .value (tmr_value),
      .zero  (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_FETCH;
         instr_idx  <= '0;
         cur        <= '0;
         first_pass <= 1'b1;
         lim_sel    <= 1'b0;
         acq_cnt    <= '0;
      end else if (soft_rst) begin
         state      <= ST_FETCH;
         instr_idx  <= '0;
         cur        <= '0;
         first_pass <= 1'b1;
         lim_sel    <= 1'b0;
         acq_cnt    <= '0;
      end else begin
         unique case (state)
            ST_FETCH: begin
               cur   <= instr_t'(instr_word);
               state <= ST_CHECK;
            end
            ST_CHECK: begin
               if (cur.pause && !first_pass) state <= ST_HOLD;
               else if (start)               state <= ST_EXEC;
               else                          state <= ST_HOLD;
            end
            ST_HOLD: begin
               if (start) state <= ST_EXEC;
            end
            ST_EXEC: begin
               first_pass <= 1'b0;
               lim_sel    <= 1'b0;
               acq_cnt    <= '0;
               state      <= cur.tmr ? ST_TWAIT : ST_ACQ;
            end
            ST_TWAIT: begin
               if (tmr_zero) state <= ST_ACQ;
            end
            ST_ACQ: begin
               if (acq_cnt == ACQ_END) state <= ST_ARM;
               else                    acq_cnt <= acq_cnt + 1'b1;
            end
            ST_ARM: begin
               if (!cur.sync || sync_rise) state <= ST_CONV;
            end
            ST_CONV: begin
               if (conv_done) begin
                  if (cur.cmp && !lim_sel) begin
                     lim_sel <= 1'b1;
                     state   <= ST_ARM;
                  end else begin
                     if (cur.last || instr_idx == LAST_IDX) instr_idx <= '0;
                     else                                   instr_idx <= instr_idx + 1'b1;
                     state <= ST_FETCH;
                  end
               end
            end
            default: state <= ST_FETCH;
         endcase
      end
   end

   assign pos_ch      = cur.pos;
   assign neg_ch      = cur.neg;
   assign neg_gnd     = (cur.neg == 3'b000);
   assign res_8bit    = cur.res8;
   assign cmp_mode    = cur.cmp;
   assign conv_req    = (state == ST_CONV);
   assign pause_irq   = (state == ST_CHECK) && cur.pause && !first_pass;
   assign start_clr   = pause_irq;
   assign unused_rsvd = ^cur.rsvd;

   assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (conv_req && !conv_done) |=> conv_req);

   assert_req_drop_R12: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (conv_req && conv_done) |=> !conv_req);

   assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (instr_idx != $past(instr_idx)) |-> (instr_idx == '0 || instr_idx == $past(instr_idx) + 1'b1));

   assert_soft_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (instr_idx == '0 && !conv_req));

   assert_pause_stops_R4: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      pause_irq |=> (!conv_req && $stable(instr_idx)));

   assert_timer_gate_R11: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (state == ST_TWAIT && !tmr_zero) |=> (state == ST_TWAIT && !conv_req));

endmodule

// File: tb/conv_seq_bench.sv
module conv_seq_bench;

   localparam int IDX_W = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        start_reg = 1'b0;
   logic        start_set = 1'b0;
   logic        start_wr0 = 1'b0;
   logic [15:0] ram [8];
   logic [15:0] instr_word;
   logic        sync_in = 1'b0;
   logic [15:0] tmr_value = '0;
   logic        conv_done;
   logic [1:0]  dcnt;
   logic [IDX_W-1:0] instr_idx;
   logic [2:0]  pos_ch, neg_ch;
   logic        neg_gnd, res_8bit, cmp_mode, lim_sel, conv_req, pause_irq, start_clr;

   int n_vec = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   assign instr_word = ram[instr_idx];

   conv_seq u_conv_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .start      (start_reg),
      .instr_word (instr_word),
      .sync_in    (sync_in),
      .tmr_value  (tmr_value),
      .conv_done  (conv_done),
      .instr_idx  (instr_idx),
      .pos_ch     (pos_ch),
      .neg_ch     (neg_ch),
      .neg_gnd    (neg_gnd),
      .res_8bit   (res_8bit),
      .cmp_mode   (cmp_mode),
      .lim_sel    (lim_sel),
      .conv_req   (conv_req),
      .pause_irq  (pause_irq),
      .start_clr  (start_clr)
   );

   // host run bit: cleared by the block's pulse on the same edge
   always @(posedge clk) begin
      if (start_set)                   start_reg <= 1'b1;
      else if (start_clr || start_wr0) start_reg <= 1'b0;
   end

   // converter model: done three edges after the request is seen
   always @(posedge clk) begin
      if (!rst_n) begin
         conv_done <= 1'b0;
         dcnt      <= '0;
      end else if (conv_req && !conv_done) begin
         if (dcnt == 2'd2) begin
            conv_done <= 1'b1;
            dcnt      <= '0;
         end else dcnt <= dcnt + 1'b1;
      end else begin
         conv_done <= 1'b0;
         dcnt      <= '0;
      end
   end

   // request recorder
   int   rec_n = 0;
   int   irq_n = 0;
   int   clr_n = 0;
   int   run_len = 0;
   int   last_len = 0;
   logic req_q = 1'b0;
   int   r_idx [512];
   int   r_pos [512];
   int   r_neg [512];
   int   r_gnd [512];
   int   r_res [512];
   int   r_cmp [512];
   int   r_lim [512];

   always @(negedge clk) begin
      if (conv_req) begin
         if (!req_q) begin
            if (rec_n < 512) begin
               r_idx[rec_n] = int'(instr_idx);
               r_pos[rec_n] = int'(pos_ch);
               r_neg[rec_n] = int'(neg_ch);
               r_gnd[rec_n] = int'(neg_gnd);
               r_res[rec_n] = int'(res_8bit);
               r_cmp[rec_n] = int'(cmp_mode);
               r_lim[rec_n] = int'(lim_sel);
            end
            rec_n   = rec_n + 1;
            run_len = 1;
         end else run_len = run_len + 1;
      end else if (req_q) last_len = run_len;
      if (pause_irq) irq_n = irq_n + 1;
      if (start_clr) clr_n = clr_n + 1;
      req_q = conv_req;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_soft_reset();
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
   endtask

   task automatic set_start();
      start_set = 1'b1;
      @(negedge clk);
      start_set = 1'b0;
   endtask

   task automatic clear_start();
      start_wr0 = 1'b1;
      @(negedge clk);
      start_wr0 = 1'b0;
   endtask

   task automatic wait_req(output int lat);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!conv_req && lat < 3000);
   endtask

   task automatic wait_rec(input int target);
      int guard = 0;
      while (rec_n < target && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic stop_run();
      int guard = 0;
      clear_start();
      while (conv_req && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      cyc(20);
   endtask

   function automatic logic [15:0] mk(input int pos, input int neg, input bit last,
                                      input bit pause, input bit sync, input bit tmr,
                                      input bit res8, input bit cmp);
      logic [15:0] w;
      w = '0;
      w[0]   = last;
      w[1]   = pause;
      w[4:2] = pos[2:0];
      w[7:5] = neg[2:0];
      w[8]   = sync;
      w[9]   = tmr;
      w[10]  = res8;
      w[11]  = cmp;
      return w;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin : main
      int base, ibase, cbase, lat, lat0, k;
      for (int i = 0; i < 8; i++) ram[i] = '0;
      ram[0] = mk(1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(4);
      rst_n = 1'b1;
      cyc(20);

      // R1: reset state, entry 0 latched, waiting for start
      chk("R1 idx after reset", int'(instr_idx), 0);
      chk("R1 req after reset", int'(conv_req), 0);
      chk("R1 irq after reset", int'(pause_irq), 0);
      chk("R1 no request without start", rec_n, 0);
      chk("R1 entry 0 decoded while holding", int'(pos_ch), 1);

      // R2 and R6: four-entry looped program
      for (int i = 0; i < 4; i++) ram[i] = mk(i, (i + 1) % 8, (i == 3), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_soft_reset();
      base = rec_n;
      set_start();
      wait_rec(base + 8);
      for (int j = 0; j < 8; j++) begin
         chk("R2 looped index", r_idx[base + j], j % 4);
         chk("R6 pos channel", r_pos[base + j], j % 4);
         chk("R6 neg channel", r_neg[base + j], (j % 4 + 1) % 8);
      end
      chk("R12 request length", last_len, 4);
      stop_run();

      // R3: eight entries, no sequence end
      for (int i = 0; i < 8; i++) ram[i] = mk(i, 7 - i, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_soft_reset();
      base = rec_n;
      set_start();
      wait_rec(base + 10);
      for (int j = 0; j < 10; j++) begin
         chk("R3 wrapping index", r_idx[base + j], j % 8);
         chk("R6 ground flag", r_gnd[base + j], ((7 - (j % 8)) == 0) ? 1 : 0);
      end

      // R7: clear start while a request is active
      while (!conv_req) @(negedge clk);
      k = int'(instr_idx);
      clear_start();
      base = rec_n;
      cyc(100);
      chk("R7 no request after stop", rec_n, base);
      chk("R7 request finished", int'(conv_req), 0);
      chk("R7 idle on next entry", int'(instr_idx), (k + 1) % 8);

      // R5 and R4: halt on entry 0
      for (int i = 0; i < 8; i++) ram[i] = '0;
      ram[0] = mk(1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      ram[1] = mk(2, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      ram[2] = mk(3, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_soft_reset();
      base = rec_n;
      ibase = irq_n;
      cbase = clr_n;
      set_start();
      wait_rec(base + 1);
      chk("R5 first pass entry 0 executes", r_idx[base], 0);
      chk("R5 no irq on first pass", irq_n, ibase);
      cyc(120);
      chk("R4 three requests before halt", rec_n, base + 3);
      chk("R4 one halt interrupt", irq_n, ibase + 1);
      chk("R4 one start clear", clr_n, cbase + 1);
      chk("R4 start bit cleared", int'(start_reg), 0);
      chk("R4 halted at entry 0", int'(instr_idx), 0);
      set_start();
      wait_rec(base + 4);
      chk("R4 resume executes entry 0", r_idx[base + 3], 0);
      chk("R4 no irq on resume", irq_n, ibase + 1);
      stop_run();

      // R4: halt on entry 1 even on first pass
      ram[0] = mk(1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      ram[1] = mk(2, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      do_soft_reset();
      base = rec_n;
      ibase = irq_n;
      set_start();
      cyc(80);
      chk("R4 halt before entry 1", rec_n, base + 1);
      chk("R4 halted index", int'(instr_idx), 1);
      chk("R4 irq at entry 1", irq_n, ibase + 1);
      chk("R4 start cleared at entry 1", int'(start_reg), 0);

      // R8: soft reset during a request
      for (int i = 0; i < 4; i++) ram[i] = mk(i, 1, (i == 3), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_soft_reset();
      set_start();
      wait_rec(rec_n + 2);
      while (!conv_req) @(negedge clk);
      do_soft_reset();
      chk("R8 index cleared", int'(instr_idx), 0);
      chk("R8 request dropped", int'(conv_req), 0);
      stop_run();

      // R6: sweep of all channel codes with alternating resolution
      for (int c = 0; c < 64; c++) begin
         for (int i = 0; i < 8; i++) ram[i] = '0;
         ram[0] = mk(c % 8, c / 8, 1'b1, 1'b0, 1'b0, 1'b0, c[0], 1'b0);
         do_soft_reset();
         set_start();
         wait_req(lat);
         chk("R6 sweep pos", int'(pos_ch), c % 8);
         chk("R6 sweep neg", int'(neg_ch), c / 8);
         chk("R6 sweep ground", int'(neg_gnd), (c / 8 == 0) ? 1 : 0);
         chk("R6 sweep resolution", int'(res_8bit), c % 2);
         stop_run();
      end

      // R11: delay latency against a baseline
      ram[0] = mk(2, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_soft_reset();
      cyc(5);
      set_start();
      wait_req(lat0);
      stop_run();
      for (int t = 0; t < 5; t++) begin
         int nval;
         nval = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 7 : (t == 3) ? 40 : 255;
         tmr_value = 16'(nval);
         ram[0] = mk(2, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
         do_soft_reset();
         cyc(5);
         set_start();
         wait_req(lat);
         chk("R11 delay latency", lat, lat0 + nval + 1);
         stop_run();
      end

      // R9: sync-gated conversion
      ram[0] = mk(5, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      sync_in = 1'b0;
      do_soft_reset();
      base = rec_n;
      set_start();
      cyc(60);
      chk("R9 no request before edge", rec_n, base);
      sync_in = 1'b1;
      wait_req(lat);
      chk("R9 edge to request", lat, 3);
      stop_run();
      sync_in = 1'b0;
      cyc(5);

      // R10: comparison with sync, two edges
      ram[0] = mk(4, 2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      do_soft_reset();
      base = rec_n;
      set_start();
      cyc(40);
      sync_in = 1'b1;
      wait_req(lat);
      chk("R10 first limit", int'(lim_sel), 0);
      chk("R10 compare mode", int'(cmp_mode), 1);
      cyc(60);
      chk("R10 second waits for edge", rec_n, base + 1);
      sync_in = 1'b0;
      cyc(5);
      sync_in = 1'b1;
      wait_req(lat);
      chk("R10 second limit", int'(lim_sel), 1);
      chk("R10 same entry", int'(instr_idx), 0);
      stop_run();
      sync_in = 1'b0;

      // R10: comparison without sync
      ram[0] = mk(3, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      do_soft_reset();
      base = rec_n;
      set_start();
      wait_rec(base + 2);
      stop_run();
      chk("R10 unsynced first limit", r_lim[base], 0);
      chk("R10 unsynced second limit", r_lim[base + 1], 1);
      chk("R10 both on entry 0", r_idx[base + 1], 0);
      chk("R10 compare flag recorded", r_cmp[base], 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule